// File: doc/BRIEF.md
# Width-Selectable ALU with Status Flags

This block is the arithmetic and logic core of a microcoded datapath that is 32 bits wide. A small width code, set at run time, picks the active operand width anywhere from a single bit up to the full datapath. This lets one piece of hardware run machine widths such as 12, 18 or 24 bits. Operand bits above the active width are ignored, and result bits above it are driven to zero. Carry, overflow and sign are taken at the chosen top bit, not at bit 31.

A five-bit function code selects the operation. When its top bit is low, one of 16 two-input logic functions is used, given directly as a truth table. When its top bit is high, one of 16 arithmetic functions is used. A carry-in generator supplies constant 0, constant 1, the stored carry flag or its complement. The status outputs are carry, overflow, minus, zero and parity. Each of them can be latched into its own flag flip-flop under a per-flag write enable. Three combined branch conditions are derived from the live status. The unit is combinational apart from those flags. Its adder uses lookahead inside 8-bit chunks, and the carry ripples from chunk to chunk.

Top module: `wsel_alu`

## Requirements
- R1: With func[4]=0, result bit i equals func[{a_i,b_i}], the truth-table bit indexed by 2*a_i+b_i (e.g. func=5'b01000 is AND, 5'b00110 is XOR, 5'b00011 is NOT A), within the active width.
- R2: With func[4]=1, func[3:0] selects X+Y+cin with (X,Y) = 0:(A,B) 1:(A,~B) 2:(~A,B) 3:(A,0) 4:(B,0) 5:(~A,0) 6:(~B,0) 7:(A,A) 8:(A,ones) 9:(B,ones) 10:(0,0) 11:(~A,~B) 12:(B,B) 13:(~B,ones) 14:(~A,ones) 15:(0,ones), all taken at the active width.
- R3: A width code w makes w+1 bits active (31 selects 32 bits). Operand bits above bit w are ignored, and result bits above bit w are zero.
- R4: The cin_mode value selects the carry input: 0 gives 0, 1 gives 1, 2 gives the stored carry flag, 3 gives its complement.
- R5: carry_o is the carry out of bit w for arithmetic functions and is 0 for logic functions.
- R6: ovf_o is the carry into bit w XOR the carry out of bit w for arithmetic functions, and is 0 for logic functions. minus_o equals result bit w.
- R7: zero_o is 1 when all active result bits are 0. parity_o is 1 when the number of ones in the active result is odd.
- R8: At a rising clock edge, each flag whose flag_we bit is set (bit 0 carry, 1 overflow, 2 minus, 3 zero, 4 parity) takes the live status value. A flag whose bit is clear keeps its value.
- R9: A synchronous active-high rst clears all five flags.
- R10: cond_zc = zero|carry, cond_nv = minus^overflow and cond_znv = zero|(minus^overflow), all formed from the live status.
- R11: Carries cross the 8-bit chunk boundaries, so at full width 0x00FFFFFF+1 gives 0x01000000 and 0xFFFFFFFF+1 gives 0 with carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| func | input | 5 | Function code: bit 4 selects arithmetic, bits 3:0 the function |
| width_code | input | 5 | Active width minus one |
| cin_mode | input | 2 | Carry-in source select |
| flag_we | input | 5 | Per-flag capture enable |
| result | output | 32 | Result, zero above the active width |
| carry_o | output | 1 | Live carry at the top active bit |
| ovf_o | output | 1 | Live signed overflow |
| minus_o | output | 1 | Live sign (top active result bit) |
| zero_o | output | 1 | Live zero detect |
| parity_o | output | 1 | Live odd parity of the result |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_n | output | 1 | Stored minus flag |
| flag_z | output | 1 | Stored zero flag |
| flag_p | output | 1 | Stored parity flag |
| cond_zc | output | 1 | Zero or carry |
| cond_nv | output | 1 | Minus xor overflow |
| cond_znv | output | 1 | Zero or (minus xor overflow) |

## Verification
A fault in the width mask or in the chunk carry path shows up at the result and the live flags in the same cycle as the operands are applied. Carry and overflow pick out the selected top bit, so a carry vector that is off by one position corrupts them at once for any width whose top bit is not bit 31. The only internal state is the five flags. A wrong flag appears one edge after capture, or later when a stored-carry mode turns it into a result that is off by one.

// File: rtl/wsel_alu_pkg.sv
package wsel_alu_pkg;

    localparam int ALU_DW    = 32;
    localparam int ALU_CHUNK = 8;
    localparam int FN_W      = 5;
    localparam int NFLAGS    = 5;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_FLAG  = 2'd2,
        CIN_NFLAG = 2'd3
    } cin_mode_e;

    typedef enum logic [2:0] {
        SX_A, SX_NA, SX_B, SX_NB, SX_ZERO
    } xsel_e;

    typedef enum logic [2:0] {
        SY_B, SY_NB, SY_A, SY_ZERO, SY_ONES
    } ysel_e;

    typedef struct packed {
        xsel_e x;
        ysel_e y;
    } opsel_t;

    // bit 0 carry, 1 overflow, 2 minus, 3 zero, 4 parity
    typedef struct packed {
        logic p;
        logic z;
        logic n;
        logic v;
        logic c;
    } status_t;

    function automatic opsel_t arith_decode(input logic [3:0] code);
        opsel_t s;
        case (code)
            4'd0:    s = '{SX_A,    SY_B};
            4'd1:    s = '{SX_A,    SY_NB};
            4'd2:    s = '{SX_NA,   SY_B};
            4'd3:    s = '{SX_A,    SY_ZERO};
            4'd4:    s = '{SX_B,    SY_ZERO};
            4'd5:    s = '{SX_NA,   SY_ZERO};
            4'd6:    s = '{SX_NB,   SY_ZERO};
            4'd7:    s = '{SX_A,    SY_A};
            4'd8:    s = '{SX_A,    SY_ONES};
            4'd9:    s = '{SX_B,    SY_ONES};
            4'd10:   s = '{SX_ZERO, SY_ZERO};
            4'd11:   s = '{SX_NA,   SY_NB};
            4'd12:   s = '{SX_B,    SY_B};
            4'd13:   s = '{SX_NB,   SY_ONES};
            4'd14:   s = '{SX_NA,   SY_ONES};
            default: s = '{SX_ZERO, SY_ONES};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/alu_cin_gen.sv
module alu_cin_gen
    import wsel_alu_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       stored_c,
    output logic       cin
);
    cin_mode_e m;
    assign m = cin_mode_e'(mode);

    always_comb begin
        case (m)
            CIN_ZERO:  cin = 1'b0;
            CIN_ONE:   cin = 1'b1;
            CIN_FLAG:  cin = stored_c;
            default:   cin = ~stored_c;
        endcase
    end
endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import wsel_alu_pkg::*;
#(
    parameter int DW = ALU_DW
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] mask,
    input  logic [3:0]    code,
    output logic [DW-1:0] x,
    output logic [DW-1:0] y
);
    opsel_t sel;
    logic [DW-1:0] x_raw, y_raw;

    assign sel = arith_decode(code);

    always_comb begin
        case (sel.x)
            SX_A:    x_raw = a;
            SX_NA:   x_raw = ~a;
            SX_B:    x_raw = b;
            SX_NB:   x_raw = ~b;
            default: x_raw = '0;
        endcase
        case (sel.y)
            SY_B:    y_raw = b;
            SY_NB:   y_raw = ~b;
            SY_A:    y_raw = a;
            SY_ONES: y_raw = '1;
            default: y_raw = '0;
        endcase
    end

    assign x = x_raw & mask;
    assign y = y_raw & mask;
endmodule

// File: rtl/alu_cla_chunk.sv
module alu_cla_chunk #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic          cin,
    output logic [CW-1:0] sum,
    output logic [CW:0]   cy
);
    logic [CW-1:0] g, p;
    assign g = x & y;
    assign p = x ^ y;

    // flat sum-of-products carry for each position inside the chunk
    always_comb begin
        for (int j = 0; j <= CW; j++) begin
            logic term;
            logic acc;
            term = cin;
            for (int k = 0; k < j; k++) term = term & p[k];
            acc = term;
            for (int k = 0; k < j; k++) begin
                logic t;
                t = g[k];
                for (int m = k + 1; m < j; m++) t = t & p[m];
                acc = acc | t;
            end
            cy[j] = acc;
        end
    end

    assign sum = p ^ cy[CW-1:0];
endmodule

// File: rtl/alu_adder.sv
module alu_adder
    import wsel_alu_pkg::*;
#(
    parameter int DW = ALU_DW,
    parameter int CW = ALU_CHUNK
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic [DW:0]   cvec
);
    localparam int NCH = DW / CW;

    logic [NCH:0] chain;
    assign chain[0] = cin;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chunk
        logic [CW:0] cy;
        alu_cla_chunk #(.CW(CW)) u_cla (
            .x   (x[ch*CW +: CW]),
            .y   (y[ch*CW +: CW]),
            .cin (chain[ch]),
            .sum (sum[ch*CW +: CW]),
            .cy  (cy)
        );
        assign cvec[ch*CW +: CW] = cy[CW-1:0];
        assign chain[ch+1]       = cy[CW];
    end

    assign cvec[DW] = chain[NCH];
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
    parameter int NF = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] we,
    input  logic [NF-1:0] d,
    output logic [NF-1:0] q
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= 1'b0;
            else if (we[i]) q[i] <= d[i];
        end
    end
endmodule

// File: rtl/wsel_alu.sv
module wsel_alu
    import wsel_alu_pkg::*;
#(
    parameter int DW  = ALU_DW,
    parameter int CW  = ALU_CHUNK,
    localparam int WCW = $clog2(DW)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DW-1:0]       op_a,
    input  logic [DW-1:0]       op_b,
    input  logic [FN_W-1:0]     func,
    input  logic [WCW-1:0]      width_code,
    input  logic [1:0]          cin_mode,
    input  logic [NFLAGS-1:0]   flag_we,
    output logic [DW-1:0]       result,
    output logic                carry_o,
    output logic                ovf_o,
    output logic                minus_o,
    output logic                zero_o,
    output logic                parity_o,
    output logic                flag_c,
    output logic                flag_v,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_p,
    output logic                cond_zc,
    output logic                cond_nv,
    output logic                cond_znv
);
    logic [DW-1:0] mask, am, bm, lres, x, y, sum;
    logic [DW:0]   cvec;
    logic          cin, is_arith;
    logic [WCW:0]  top_out;
    status_t       live, stored;

    // active-width mask: bits 0..width_code set
    always_comb begin
        for (int i = 0; i < DW; i++) mask[i] = (i <= int'(width_code));
    end

    assign am       = op_a & mask;
    assign bm       = op_b & mask;
    assign is_arith = func[FN_W-1];

    // logic path: func[3:0] is the truth table, indexed by {a,b}
    always_comb begin
        for (int i = 0; i < DW; i++) lres[i] = func[{am[i], bm[i]}];
    end

    alu_operand_sel #(.DW(DW)) u_opsel (
        .a    (am),
        .b    (bm),
        .mask (mask),
        .code (func[3:0]),
        .x    (x),
        .y    (y)
    );

    alu_cin_gen u_cin (
        .mode     (cin_mode),
        .stored_c (stored.c),
        .cin      (cin)
    );

    alu_adder #(.DW(DW), .CW(CW)) u_add (
        .x    (x),
        .y    (y),
        .cin  (cin),
        .sum  (sum),
        .cvec (cvec)
    );

    assign top_out = {1'b0, width_code} + 1'b1;
    assign result  = (is_arith ? sum : lres) & mask;

    assign live.c = is_arith & cvec[top_out];
    assign live.v = is_arith & (cvec[top_out] ^ cvec[width_code]);
    assign live.n = result[width_code];
    assign live.z = ~|result;
    assign live.p = ^result;

    alu_flag_reg #(.NF(NFLAGS)) u_flags (
        .clk (clk),
        .rst (rst),
        .we  (flag_we),
        .d   (live),
        .q   (stored)
    );

    assign carry_o  = live.c;
    assign ovf_o    = live.v;
    assign minus_o  = live.n;
    assign zero_o   = live.z;
    assign parity_o = live.p;

    assign flag_c = stored.c;
    assign flag_v = stored.v;
    assign flag_n = stored.n;
    assign flag_z = stored.z;
    assign flag_p = stored.p;

    assign cond_zc  = live.z | live.c;
    assign cond_nv  = live.n ^ live.v;
    assign cond_znv = live.z | cond_nv;
endmodule

// File: rtl/wsel_alu_chk.sv
module wsel_alu_chk #(
    parameter int DW  = 32,
    parameter int WCW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic [4:0]     func,
    input logic [WCW-1:0] width_code,
    input logic [4:0]     flag_we,
    input logic [DW-1:0]  result,
    input logic           carry_o,
    input logic           ovf_o,
    input logic           zero_o,
    input logic           flag_c,
    input logic           flag_v,
    input logic           flag_n,
    input logic           flag_z,
    input logic           flag_p,
    input logic           cond_nv,
    input logic           cond_znv
);
    logic [DW-1:0] upper;
    always_comb begin
        for (int i = 0; i < DW; i++) upper[i] = (i > int'(width_code));
    end

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (result & upper) == '0);

    a_r5_logic_no_carry: assert property (@(posedge clk) disable iff (rst)
        !func[4] |-> (!carry_o && !ovf_o));

    a_r7_zero_detect: assert property (@(posedge clk) disable iff (rst)
        zero_o == (result == '0));

    a_r8_carry_hold: assert property (@(posedge clk) disable iff (rst)
        !flag_we[0] |=> $stable(flag_c));

    a_r8_zero_capture: assert property (@(posedge clk) disable iff (rst)
        flag_we[3] |=> (flag_z == $past(zero_o)));

    a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ({flag_p, flag_z, flag_n, flag_v, flag_c} == 5'b0));

    a_r10_cond_combine: assert property (@(posedge clk) disable iff (rst)
        cond_znv == (zero_o | cond_nv));
endmodule

bind wsel_alu wsel_alu_chk #(.DW(DW), .WCW(WCW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .func       (func),
    .width_code (width_code),
    .flag_we    (flag_we),
    .result     (result),
    .carry_o    (carry_o),
    .ovf_o      (ovf_o),
    .zero_o     (zero_o),
    .flag_c     (flag_c),
    .flag_v     (flag_v),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_p     (flag_p),
    .cond_nv    (cond_nv),
    .cond_znv   (cond_znv)
);

// File: tb/test_wsel_alu.sv
module test_wsel_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0, op_b = '0;
    logic [4:0]  func = '0, width_code = 5'd31, flag_we = '0;
    logic [1:0]  cin_mode = '0;
    logic [31:0] result;
    logic carry_o, ovf_o, minus_o, zero_o, parity_o;
    logic flag_c, flag_v, flag_n, flag_z, flag_p;
    logic cond_zc, cond_nv, cond_znv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wsel_alu i_wsel_alu (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .func(func),
        .width_code(width_code), .cin_mode(cin_mode), .flag_we(flag_we),
        .result(result), .carry_o(carry_o), .ovf_o(ovf_o), .minus_o(minus_o),
        .zero_o(zero_o), .parity_o(parity_o), .flag_c(flag_c), .flag_v(flag_v),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p), .cond_zc(cond_zc),
        .cond_nv(cond_nv), .cond_znv(cond_znv)
    );

    typedef struct packed {
        logic [4:0]  fn;
        logic [4:0]  w;
        logic [1:0]  cm;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        c;
        logic        v;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{5'd16, 5'd31, 2'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R11 R2
        '{5'd16, 5'd7,  2'd0, 32'h0000007F, 32'h00000001, 32'h00000080, 1'b0, 1'b1}, // R6
        '{5'd16, 5'd11, 2'd0, 32'hABCDEFFF, 32'hFFFFF001, 32'h00000000, 1'b1, 1'b0}, // R3
        '{5'd17, 5'd15, 2'd1, 32'h00000005, 32'h00000007, 32'h0000FFFE, 1'b0, 1'b0}, // R4
        '{5'd17, 5'd15, 2'd1, 32'h00008000, 32'h00000001, 32'h00007FFF, 1'b1, 1'b1}, // R6
        '{5'd8,  5'd31, 2'd0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0}, // R1 AND
        '{5'd6,  5'd23, 2'd0, 32'h12345678, 32'h00FF00FF, 32'h00CB5687, 1'b0, 1'b0}, // R1 XOR
        '{5'd3,  5'd0,  2'd0, 32'h00000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0}, // R1 NOT A, 1 bit
        '{5'd19, 5'd17, 2'd1, 32'h0001FFFF, 32'h00000000, 32'h00020000, 1'b0, 1'b1}, // R2 inc
        '{5'd23, 5'd4,  2'd0, 32'h00000013, 32'h00000000, 32'h00000006, 1'b1, 1'b1}, // R2 double
        '{5'd26, 5'd31, 2'd1, 32'h12345678, 32'h9ABCDEF0, 32'h00000001, 1'b0, 1'b0}, // R2 cin only
        '{5'd31, 5'd7,  2'd0, 32'h00000000, 32'h00000000, 32'h000000FF, 1'b0, 1'b0}, // R2 ones
        '{5'd15, 5'd12, 2'd0, 32'h00000000, 32'h00000000, 32'h00001FFF, 1'b0, 1'b0}, // R7 parity
        '{5'd18, 5'd7,  2'd1, 32'h00000003, 32'h0000000A, 32'h00000007, 1'b1, 1'b0}, // R2 B-A
        '{5'd16, 5'd31, 2'd0, 32'h00FFFFFF, 32'h00000001, 32'h01000000, 1'b0, 1'b0}, // R11 chunks
        '{5'd10, 5'd3,  2'd0, 32'h00000000, 32'hFFFFFFF5, 32'h00000005, 1'b0, 1'b0}  // R3 pass B
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        func = v.fn; width_code = v.w; cin_mode = v.cm; op_a = v.a; op_b = v.b;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    function automatic logic [4:0] flags();
        return {flag_p, flag_z, flag_n, flag_v, flag_c};
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 flags after reset", {27'd0, flags()}, 32'd0);

        // table walk: live outputs only, no flag writes
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            v = VEC[k];
            @(negedge clk);
            drive(v);
            #1;
            chk($sformatf("R1/R2/R3 result vec%0d", k), result, v.res);
            chk($sformatf("R5 carry vec%0d", k), {31'd0, carry_o}, {31'd0, v.c});
            chk($sformatf("R6 overflow vec%0d", k), {31'd0, ovf_o}, {31'd0, v.v});
            chk($sformatf("R6 minus vec%0d", k), {31'd0, minus_o}, {31'd0, v.res[v.w]});
            chk($sformatf("R7 zero vec%0d", k), {31'd0, zero_o}, {31'd0, v.res == 32'd0});
            chk($sformatf("R7 parity vec%0d", k), {31'd0, parity_o}, {31'd0, ^v.res});
        end

        // R10 derived conditions
        @(negedge clk); drive(VEC[1]); #1;
        chk("R10 conds vec1", {29'd0, cond_zc, cond_nv, cond_znv}, {29'd0, 3'b000});
        @(negedge clk); drive(VEC[3]); #1;
        chk("R10 conds vec3", {29'd0, cond_zc, cond_nv, cond_znv}, {29'd0, 3'b011});
        @(negedge clk); drive(VEC[0]); #1;
        chk("R10 conds vec0", {29'd0, cond_zc, cond_nv, cond_znv}, {29'd0, 3'b101});

        // R8 capture all flags from vec0: p0 z1 n0 v0 c1
        @(negedge clk); drive(VEC[0]); flag_we = 5'b11111;
        tick();
        flag_we = 5'b0;
        chk("R8 capture all", {27'd0, flags()}, {27'd0, 5'b01001});

        // R4 stored-carry modes (carry flag is 1)
        func = 5'd26; width_code = 5'd31; cin_mode = 2'd2; #1;
        chk("R4 cin stored", result, 32'd1);
        cin_mode = 2'd3; #1;
        chk("R4 cin inverted", result, 32'd0);

        // R8 hold with enables low
        @(negedge clk); drive(VEC[1]); flag_we = 5'b0;
        tick();
        chk("R8 hold", {27'd0, flags()}, {27'd0, 5'b01001});

        // R8 per-flag write: carry only, then minus only
        drive(VEC[1]); flag_we = 5'b00001;
        tick();
        chk("R8 carry only", {27'd0, flags()}, {27'd0, 5'b01000});
        flag_we = 5'b00100;
        tick();
        flag_we = 5'b0;
        chk("R8 minus only", {27'd0, flags()}, {27'd0, 5'b01100});

        // R9 reset clears stored flags
        rst = 1'b1;
        tick();
        rst = 1'b0;
        #1;
        chk("R9 reset clears", {27'd0, flags()}, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule